// File: doc/BRIEF.md
# Byte-Wide Slave Parallel Configuration Loader

This block loads a configuration bitstream into an FPGA through its byte-wide slave parallel port. Bytes arrive on a valid/ready input. For each byte, the block places the byte on the data pins first. Only after that does it produce one configuration clock pulse. Each rising edge is therefore generated on purpose once the data has settled. The clock is never free-running, so there is no skew between the select strobe and the clock.

A session begins on `start_i`. If `clear_i` is set at the same time, the block first pulses the program line low for a fixed number of cycles to erase the target's configuration memory. It then waits for the target's init line to go high, which is when the target can accept data. It streams the bytes with select and write strobes held low. After the byte flagged as last, it keeps clocking until the target reports done. It then supplies a fixed number of extra clocks so the target can finish its startup sequence. If done never arrives, the block raises an error flag.

Top module: `pcfg_loader`

## Requirements
- R1: Reset state: `prog_no`, `csn_o` and `rdwrn_o` are 1; `cclk_o`, `ready_o`, `cfg_done_o` and `err_o` are 0.
- R2: `start_i` with `clear_i`=1 drives `prog_no` low for exactly PROG_CYC cycles. `start_i` with `clear_i`=0 leaves `prog_no` high.
- R3: While `init_ni` is low, `csn_o` stays high and no byte is accepted. Transfer begins only after `init_ni` is seen high.
- R4: During transfer, `csn_o` and `rdwrn_o` are 0. Each accepted byte appears on `data_o` at exactly one rising edge of `cclk_o`, in acceptance order.
- R5: `data_o` is stable for at least HALF_CYC cycles before each `cclk_o` rising edge and does not change while `cclk_o` is high. Each high phase and each low phase of `cclk_o` lasts at least HALF_CYC cycles.
- R6: While `busy_i` is 1, `cclk_o` does not rise.
- R7: Once `done_i` is seen after the last byte, exactly STARTUP_CLKS further `cclk_o` rising edges occur. After that, `cfg_done_o` becomes 1 with `csn_o` and `rdwrn_o` at 1 and `cclk_o` at 0.
- R8: If `done_i` stays low, `err_o` becomes 1 after DONE_TMO rising edges. The count starts at the last byte's edge and includes it. No further edges follow and `csn_o` returns to 1. A new `start_i` clears `err_o`.
- R9: `ready_o` is 1 only during transfer while `cclk_o` is low and no pulse is in progress. One handshake moves one byte.
- R10: `cclk_o` is never 1 while `csn_o` is 1. While `prog_no` is 0, `csn_o` is 1 and `cclk_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a configuration session |
| clear_i | input | 1 | Sampled with start_i: erase target memory first |
| byte_i | input | 8 | Bitstream byte |
| valid_i | input | 1 | byte_i is valid |
| last_i | input | 1 | byte_i is the final bitstream byte |
| ready_o | output | 1 | Byte accepted when valid_i is also 1 |
| prog_no | output | 1 | Program line, low erases target |
| csn_o | output | 1 | Chip select, active low |
| rdwrn_o | output | 1 | Direction strobe, low means write |
| cclk_o | output | 1 | Controlled configuration clock |
| data_o | output | 8 | Configuration data bus |
| init_ni | input | 1 | Target init line, high when ready for data |
| done_i | input | 1 | Target done line |
| busy_i | input | 1 | Target busy line |
| cfg_done_o | output | 1 | Session finished, startup clocks sent |
| err_o | output | 1 | Done not seen in time |

## Verification
A corrupted clock-engine phase or count appears at the target pins at once: a rising edge too soon after a data change, a pulse during busy, or a byte captured twice or skipped. The next rising edge exposes it. A wrong edge counter in the done and startup stages shows as one edge too many or too few before `cfg_done_o` or `err_o`, within STARTUP_CLKS or DONE_TMO pulses. A wrong sequencer state shows as a select strobe that is low during the program pulse or while init is low, or a clock with select high, in the same cycle.

// File: rtl/pcfg_pkg.sv
package pcfg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_PROG, ST_INIT, ST_LOAD, ST_DRAIN, ST_START, ST_FIN, ST_ERR
  } ld_state_e;

  typedef enum logic [1:0] {
    PH_IDLE, PH_LOW, PH_HIGH
  } clk_phase_e;
endpackage

// File: rtl/pcfg_clkgen.sv
module pcfg_clkgen
  import pcfg_pkg::*;
#(
  parameter int HALF_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic go_i,
  input  logic hold_i,
  output logic cclk_o,
  output logic idle_o,
  output logic rise_o
);
  localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CW-1:0] RELOAD = CW'(HALF_CYC - 1);

  clk_phase_e ph_q;
  logic [CW-1:0] cnt_q;

  assign idle_o = (ph_q == PH_IDLE);
  // rising edge is committed on the next clock
  assign rise_o = (ph_q == PH_LOW) && (cnt_q == '0) && !hold_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      cclk_o <= 1'b0;
    end else begin
      unique case (ph_q)
        PH_IDLE: if (go_i) begin
          ph_q  <= PH_LOW;
          cnt_q <= RELOAD;
        end
        PH_LOW: begin
          if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
          else if (!hold_i) begin
            ph_q   <= PH_HIGH;
            cnt_q  <= RELOAD;
            cclk_o <= 1'b1;
          end
        end
        PH_HIGH: begin
          if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
          else begin
            ph_q   <= PH_IDLE;
            cclk_o <= 1'b0;
          end
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assert_no_rise_in_busy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cclk_o) |-> !$past(hold_i));
  assert_idle_clock_low_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_o |-> !cclk_o);
endmodule

// File: rtl/pcfg_evcnt.sv
module pcfg_evcnt #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= '0;
    else if (clr_i) q_o <= '0;
    else if (inc_i) q_o <= q_o + 1'b1;
  end
endmodule

// File: rtl/pcfg_loader.sv
module pcfg_loader
  import pcfg_pkg::*;
#(
  parameter int HALF_CYC     = 2,
  parameter int PROG_CYC     = 32,
  parameter int DONE_TMO     = 64,
  parameter int STARTUP_CLKS = 9
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       clear_i,
  input  logic [7:0] byte_i,
  input  logic       valid_i,
  input  logic       last_i,
  output logic       ready_o,
  output logic       prog_no,
  output logic       csn_o,
  output logic       rdwrn_o,
  output logic       cclk_o,
  output logic [7:0] data_o,
  input  logic       init_ni,
  input  logic       done_i,
  input  logic       busy_i,
  output logic       cfg_done_o,
  output logic       err_o
);
  localparam int PW   = $clog2(PROG_CYC + 1);
  localparam int EMAX = (DONE_TMO > STARTUP_CLKS) ? DONE_TMO : STARTUP_CLKS;
  localparam int EW   = $clog2(EMAX + 1);
  localparam logic [PW-1:0] PROG_LAST = PW'(PROG_CYC - 1);
  localparam logic [EW-1:0] TMO_N     = EW'(DONE_TMO);
  localparam logic [EW-1:0] SU_N      = EW'(STARTUP_CLKS);

  ld_state_e state_q, state_d;
  logic [7:0]    data_q;
  logic [PW-1:0] prog_q;
  logic [EW-1:0] ev_q;
  logic cg_go, cg_idle, cg_rise, fire, ev_clr, ev_inc, in_xfer;

  assign in_xfer = (state_q == ST_LOAD) || (state_q == ST_DRAIN) || (state_q == ST_START);
  assign ready_o = (state_q == ST_LOAD) && cg_idle;
  assign fire    = valid_i && ready_o;

  assign cg_go = fire
               || ((state_q == ST_DRAIN) && cg_idle && (ev_q != TMO_N))
               || ((state_q == ST_START) && cg_idle && (ev_q != SU_N));

  assign ev_clr = (fire && last_i) || ((state_q == ST_DRAIN) && done_i);
  assign ev_inc = cg_rise && ((state_q == ST_DRAIN) || (state_q == ST_START));

  pcfg_clkgen #(.HALF_CYC(HALF_CYC)) u_clkgen (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .go_i  (cg_go),
    .hold_i(busy_i),
    .cclk_o(cclk_o),
    .idle_o(cg_idle),
    .rise_o(cg_rise)
  );

  pcfg_evcnt #(.W(PW)) u_prog_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (state_q != ST_PROG),
    .inc_i (1'b1),
    .q_o   (prog_q)
  );

  pcfg_evcnt #(.W(EW)) u_edge_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (ev_clr),
    .inc_i (ev_inc),
    .q_o   (ev_q)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE, ST_FIN, ST_ERR:
        if (start_i) state_d = clear_i ? ST_PROG : ST_INIT;
      ST_PROG:  if (prog_q == PROG_LAST) state_d = ST_INIT;
      ST_INIT:  if (init_ni) state_d = ST_LOAD;
      ST_LOAD:  if (fire && last_i) state_d = ST_DRAIN;
      ST_DRAIN: begin
        if (done_i) state_d = ST_START;
        else if ((ev_q == TMO_N) && cg_idle) state_d = ST_ERR;
      end
      ST_START: if ((ev_q == SU_N) && cg_idle) state_d = ST_FIN;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      if (fire) data_q <= byte_i;
    end
  end

  assign prog_no    = (state_q != ST_PROG);
  assign csn_o      = !in_xfer;
  assign rdwrn_o    = !in_xfer;
  assign data_o     = data_q;
  assign cfg_done_o = (state_q == ST_FIN);
  assign err_o      = (state_q == ST_ERR);

  assert_clk_needs_select_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cclk_o |-> !csn_o);
  assert_prog_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prog_no |-> (csn_o && !cclk_o));
  assert_data_setup_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cclk_o) |-> $stable(data_o));
  assert_data_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cclk_o && $past(cclk_o)) |-> $stable(data_o));
  assert_ready_phase_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (!csn_o && !cclk_o));
  assert_finish_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_done_o |-> (csn_o && rdwrn_o && !cclk_o));
  assert_err_no_clock_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (!cclk_o && csn_o));
endmodule

// File: tb/sim_pcfg_loader.sv
module sim_pcfg_loader;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 2;
  localparam int PROG = 8;
  localparam int TMO  = 12;
  localparam int SU   = 9;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 0, clear_i = 0, valid_i = 0, last_i = 0;
  logic [7:0] byte_i = '0;
  logic init_ni = 1'b1, done_i = 1'b0, busy_i = 1'b0;
  logic ready_o, prog_no, csn_o, rdwrn_o, cclk_o, cfg_done_o, err_o;
  logic [7:0] data_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  pcfg_loader #(.HALF_CYC(HALF), .PROG_CYC(PROG), .DONE_TMO(TMO), .STARTUP_CLKS(SU)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .clear_i(clear_i),
    .byte_i(byte_i), .valid_i(valid_i), .last_i(last_i), .ready_o(ready_o),
    .prog_no(prog_no), .csn_o(csn_o), .rdwrn_o(rdwrn_o), .cclk_o(cclk_o),
    .data_o(data_o), .init_ni(init_ni), .done_i(done_i), .busy_i(busy_i),
    .cfg_done_o(cfg_done_o), .err_o(err_o)
  );

  int nchk = 0, nerr = 0;
  int rises = 0, prog_cnt = 0, ihold = 0;
  int lo_cnt = 100, hi_cnt = 0, dstable = 100;
  logic cclk_d = 0, busy_d = 0;
  logic [7:0] data_d = '0;
  logic [7:0] cap [0:255];
  logic [7:0] sent [0:255];
  bit busy_en = 0;

  task automatic check(input bit ok, input string rq, input string what,
                       input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  // target-side monitor and init model
  always @(negedge clk) begin
    if (rst_ni) begin
      if (cclk_o && !cclk_d) begin
        cap[rises[7:0]] = data_o;
        check(!busy_d, "R6", "rise while busy", 1, 0);
        check(lo_cnt >= HALF, "R5", "low width", lo_cnt, HALF);
        check(dstable >= HALF, "R5", "data setup", dstable, HALF);
        check(!csn_o && !rdwrn_o, "R4", "strobes at edge", csn_o, 0);
        rises++;
        lo_cnt = 0; hi_cnt = 0;
      end
      if (!cclk_o && cclk_d) begin
        check(hi_cnt >= HALF, "R5", "high width", hi_cnt, HALF);
        lo_cnt = 0; hi_cnt = 0;
      end
      if (data_o != data_d) begin
        if (cclk_o && cclk_d) check(0, "R5", "data moved while high", data_o, data_d);
        dstable = 1;
      end else dstable++;
      if (cclk_o) hi_cnt++; else lo_cnt++;
      if (cclk_o && csn_o) check(0, "R10", "clock with select high", 1, 0);
      if (ready_o && csn_o) check(0, "R9", "ready outside transfer", 1, 0);
      if (!init_ni && (!csn_o || ready_o)) check(0, "R3", "select while init low", csn_o, 1);
      if (!prog_no) begin
        prog_cnt++;
        check(csn_o && !cclk_o, "R10", "quiet during program", csn_o, 1);
        init_ni <= 1'b0;
        ihold   <= 6;
      end else if (ihold > 0) ihold <= ihold - 1;
      else init_ni <= 1'b1;
      cclk_d = cclk_o; data_d = data_o; busy_d = busy_i;
    end
  end

  initial forever begin
    @(posedge clk); #2;
    busy_i = busy_en && ($urandom % 5 == 0);
  end

  task automatic run_cfg(input bit clr, input int nb, input int extra, input bit give_done);
    int base, rd;
    base = rises;
    prog_cnt = 0;
    done_i = 1'b0;
    @(posedge clk); #2;
    start_i = 1'b1; clear_i = clr;
    @(posedge clk); #2;
    start_i = 1'b0; clear_i = 1'b0;
    check(!err_o && !cfg_done_o, "R8", "flags cleared by start", err_o, 0);
    for (int i = 0; i < nb; i++) begin
      logic [7:0] b;
      b = 8'($urandom);
      sent[8'(base + i)] = b;
      repeat ($urandom % 3) begin @(posedge clk); #2; end
      valid_i = 1'b1; byte_i = b; last_i = (i == nb - 1);
      while (!ready_o) begin @(posedge clk); #2; end
      @(posedge clk); #2;
      valid_i = 1'b0; last_i = 1'b0;
    end
    check(prog_cnt == (clr ? PROG : 0), "R2", "program pulse length", prog_cnt, clr ? PROG : 0);
    wait (rises >= base + nb);
    for (int i = 0; i < nb; i++)
      check(cap[8'(base + i)] == sent[8'(base + i)], "R4", "captured byte",
            cap[8'(base + i)], sent[8'(base + i)]);
    if (give_done) begin
      wait (rises >= base + nb + extra);
      @(posedge clk); #2;
      done_i = 1'b1;
      rd = rises;
      wait (cfg_done_o);
      @(negedge clk);
      check(rises - rd == SU, "R7", "startup edges", rises - rd, SU);
      check(csn_o && rdwrn_o && !cclk_o, "R7", "idle strobes after finish", csn_o, 1);
    end else begin
      wait (err_o);
      @(negedge clk);
      check(rises - base == nb - 1 + TMO, "R8", "edges before error", rises - base, nb - 1 + TMO);
      rd = rises;
      repeat (20) @(negedge clk);
      check(rises == rd, "R8", "no edges after error", rises, rd);
      check(csn_o && err_o, "R8", "select released, error held", csn_o, 1);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(prog_no && csn_o && rdwrn_o, "R1", "reset strobes", {prog_no, csn_o, rdwrn_o}, 7);
    check(!cclk_o && !ready_o, "R1", "reset clock/ready", {cclk_o, ready_o}, 0);
    check(!cfg_done_o && !err_o, "R1", "reset flags", {cfg_done_o, err_o}, 0);
    #2 rst_ni = 1'b1;
    busy_en = 1;
    run_cfg(1'b1, 24, 3, 1'b1);
    run_cfg(1'b0, 5, 0, 1'b1);
    run_cfg(1'b1, 4, 0, 1'b0);
    busy_en = 0;
    run_cfg(1'b0, 1, 5, 1'b1);
    busy_en = 1;
    run_cfg(1'b1, 40, 1, 1'b1);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL R7 watchdog expired: actual %0d expected %0d", 150000, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end
endmodule